// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point operands (1 sign bit, 8-bit exponent with bias 127, 23-bit fraction). A `sub` input negates the second operand, and a 2-bit input selects one of four rounding directions. The block returns the rounded 32-bit sum together with four exception flags: overflow, underflow (tiny result), invalid and inexact. The result and the flags are registered. They appear one clock after the operands are presented, and a new operation can start on every clock.

The datapath first places the operand of larger magnitude on the left. It then shifts the smaller significand right to match exponents, and the bits shifted out are folded into a sticky bit. The two significands are added or subtracted according to the effective operation. The sum is normalized with a leading-zero count, which is clamped so that denormal results come out correctly. The result is then rounded on a guard bit, a round bit and the sticky bit. If rounding carries out of the significand, the result is renormalized. Zeros, denormals, infinities and NaNs are handled ahead of the arithmetic path by a separate special-value path.

Top module: `fpadd_sp`

## Requirements
- R1: The registered result equals the correctly rounded sum a + b (or a - b when `sub` is 1) one clock after the operands are presented. The output holds its previous value until that edge.
- R2: The operation is an effective subtraction when sign(a) XOR sign(b) XOR `sub` is 1, and an effective addition otherwise. The result takes the sign of the operand of larger magnitude, with b's sign inverted when `sub` is 1.
- R3: `rmode` encodes 00 = nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity. Bits shifted out during alignment, including those beyond the guard position, still decide both the rounding and whether a tie exists.
- R4: When rounding carries out of the 24-bit significand, the exponent field rises by one and the fraction becomes zero.
- R5: Denormal operands (exponent field 0, fraction nonzero) take effective exponent -126 and no hidden bit. A result below 2^-126 is returned as a denormal. `flag_unf` is 1 exactly when the result has exponent field 0 and a nonzero fraction.
- R6: An exponent field of 255 or more after rounding sets `flag_ovf` and `flag_inx`. In nearest mode the result is infinity of the result's sign. In the other modes it is infinity only when the mode rounds away from zero for that sign, and the largest finite magnitude (fraction all ones, exponent 254) otherwise.
- R7: A NaN operand (exponent 255, nonzero fraction) yields 0x7FC00000. `flag_inv` is set only if one NaN operand is signaling, meaning fraction bit 22 is 0.
- R8: Infinities of opposite effective sign yield 0x7FC00000 with `flag_inv` set. An infinity combined with a finite value, or with an infinity of the same effective sign, returns that infinity with no flags.
- R9: An exact zero result from an effective subtraction is +0, except in mode 11 where it is -0. The sum of two zeros of the same effective sign keeps that sign.
- R10: `flag_inx` is 1 exactly when the returned value differs from the exact sum, that is on any nonzero guard, round or sticky bit, or on overflow.
- R11: While reset is asserted, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub | input | 1 | 1 = compute a - b, 0 = a + b |
| rmode | input | 2 | Rounding direction (see R3) |
| result | output | 32 | Registered rounded result |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Denormal (tiny) nonzero result |
| flag_inv | output | 1 | Invalid operation |
| flag_inx | output | 1 | Inexact result |

## Verification
Two functions can act in the same operation: the rounding increment and the renormalization it triggers, and rounding and overflow saturation. Operands are chosen so that a tie or a sticky-decided increment lands on an all-ones significand, producing a carry into the exponent. Other operands are chosen so that the sum of two largest finite values overflows in each rounding direction. The bench judges each case on the exact result word and on all four flags together. The checker additionally requires that an overflow result is either infinity or the largest finite magnitude.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int XTRA_W = 3;              // guard, round, sticky
  localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] word,
  output logic           sign,
  output logic [EW-1:0]  exp_eff,
  output logic [FW:0]    mant,
  output logic           is_inf,
  output logic           is_nan,
  output logic           is_snan
);
  logic [EW-1:0] exp_fld;
  logic [FW-1:0] frac;
  logic          exp_zero, exp_ones;

  assign sign     = word[EW+FW];
  assign exp_fld  = word[EW+FW-1:FW];
  assign frac     = word[FW-1:0];
  assign exp_zero = (exp_fld == '0);
  assign exp_ones = (exp_fld == '1);

  // denormals read as exponent 1 without the hidden bit
  assign exp_eff  = exp_zero ? EW'(1) : exp_fld;
  assign mant     = {~exp_zero, frac};
  assign is_inf   = exp_ones & (frac == '0);
  assign is_nan   = exp_ones & (frac != '0);
  assign is_snan  = is_nan & ~frac[FW-1];
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int EW = 8,
  parameter int MW = 24,
  parameter int XW = 3
) (
  input  logic [EW-1:0]    exp_a,
  input  logic [MW-1:0]    mant_a,
  input  logic [EW-1:0]    exp_b,
  input  logic [MW-1:0]    mant_b,
  output logic             swap,
  output logic [EW-1:0]    exp_big,
  output logic [MW+XW-1:0] big_ext,
  output logic [MW+XW-1:0] small_ext
);
  localparam int SW = MW + XW;

  logic [EW-1:0] exp_small, diff;
  logic [MW-1:0] mant_big, mant_small;
  logic [SW-1:0] raw_small, shifted, lost_mask;
  logic          lost;

  assign swap       = {exp_b, mant_b} > {exp_a, mant_a};
  assign exp_big    = swap ? exp_b  : exp_a;
  assign exp_small  = swap ? exp_a  : exp_b;
  assign mant_big   = swap ? mant_b : mant_a;
  assign mant_small = swap ? mant_a : mant_b;
  assign diff       = exp_big - exp_small;

  assign big_ext    = {mant_big, {XW{1'b0}}};
  assign raw_small  = {mant_small, {XW{1'b0}}};
  assign shifted    = raw_small >> diff;
  assign lost_mask  = ~({SW{1'b1}} << diff);
  assign lost       = |(raw_small & lost_mask);
  assign small_ext  = {shifted[SW-1:1], shifted[0] | lost};
endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int W  = 27,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpadd_norm_round.sv
module fpadd_norm_round #(
  parameter int EW = 8,
  parameter int MW = 24,
  parameter int XW = 3
) (
  input  logic [EW-1:0]    exp_big,
  input  logic [MW+XW:0]   sum,
  input  logic             sign,
  input  logic [1:0]       rmode,
  output logic [EW+MW-1:0] res_word,
  output logic             ovf,
  output logic             unf,
  output logic             inx
);
  import fpadd_pkg::*;

  localparam int SW  = MW + XW;
  localparam int CW  = $clog2(SW + 1);
  localparam int XEW = EW + 2;
  localparam logic [XEW-1:0] EMAX = XEW'((1 << EW) - 1);

  logic [CW-1:0]  lz;
  logic [XEW-1:0] lz_x, max_sh, sh, e_n, e_f;
  logic [SW-1:0]  m;
  logic [MW-1:0]  keep;
  logic [MW:0]    rnd;
  logic [MW-2:0]  frac;
  logic           lsb, grd, rest, inc, to_inf;
  rnd_mode_e      rm;

  assign rm = rnd_mode_e'(rmode);

  fpadd_lzc #(.W(SW), .CW(CW)) u_lzc (
    .vec (sum[SW-1:0]),
    .cnt (lz)
  );

  assign lz_x   = {{(XEW-CW){1'b0}}, lz};
  assign max_sh = {2'b00, exp_big} - XEW'(1);
  assign sh     = (lz_x < max_sh) ? lz_x : max_sh;

  // first normalization: right by one on carry, else left clamped at emin
  always_comb begin
    if (sum[SW]) begin
      m   = {sum[SW:2], sum[1] | sum[0]};
      e_n = {2'b00, exp_big} + XEW'(1);
    end else begin
      m   = sum[SW-1:0] << sh;
      e_n = {2'b00, exp_big} - sh;
    end
  end

  assign keep = m[SW-1:XW];
  assign lsb  = m[XW];
  assign grd  = m[XW-1];
  assign rest = grd | (|m[XW-2:0]);

  always_comb begin
    unique case (rm)
      RND_NEAR: inc = grd & ((|m[XW-2:0]) | lsb);
      RND_ZERO: inc = 1'b0;
      RND_UP:   inc = rest & ~sign;
      RND_DOWN: inc = rest & sign;
      default:  inc = 1'b0;
    endcase
  end

  assign rnd = {1'b0, keep} + {{MW{1'b0}}, inc};

  // second normalization after rounding carry-out
  always_comb begin
    if (rnd[MW]) begin
      e_f  = e_n + XEW'(1);
      frac = '0;
    end else if (rnd[MW-1]) begin
      e_f  = e_n;
      frac = rnd[MW-2:0];
    end else begin
      e_f  = '0;
      frac = rnd[MW-2:0];
    end
  end

  assign ovf    = (e_f >= EMAX);
  assign to_inf = (rm == RND_NEAR) | ((rm == RND_UP) & ~sign) | ((rm == RND_DOWN) & sign);

  always_comb begin
    if (ovf) begin
      if (to_inf) res_word = {sign, EMAX[EW-1:0], {(MW-1){1'b0}}};
      else        res_word = {sign, EMAX[EW-1:0] - EW'(1), {(MW-1){1'b1}}};
    end else begin
      res_word = {sign, e_f[EW-1:0], frac};
    end
  end

  assign inx = rest | ovf;
  assign unf = ~ovf & (e_f == '0) & (frac != '0);
endmodule

// File: rtl/fpadd_sp.sv
module fpadd_sp
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        sub,
  input  logic [1:0]  rmode,
  output logic [31:0] result,
  output logic        flag_ovf,
  output logic        flag_unf,
  output logic        flag_inv,
  output logic        flag_inx
);
  localparam int SW = MANT_W + XTRA_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic              sa, sb, sb_eff, eff_sub, swap, sign_big, zero_sign;
  logic [EXP_W-1:0]  ea, eb, exp_big;
  logic [MANT_W-1:0] ma, mb;
  logic              a_inf, a_nan, a_snan, b_inf, b_nan, b_snan;
  logic [SW-1:0]     big_ext, small_ext;
  logic [SW:0]       sum;
  logic [WORD_W-1:0] nr_word;
  logic              nr_ovf, nr_unf, nr_inx;

  fpadd_unpack #(.EW(EXP_W), .FW(FRAC_W)) u_unp_a (
    .word (op_a), .sign (sa), .exp_eff (ea), .mant (ma),
    .is_inf (a_inf), .is_nan (a_nan), .is_snan (a_snan)
  );

  fpadd_unpack #(.EW(EXP_W), .FW(FRAC_W)) u_unp_b (
    .word (op_b), .sign (sb), .exp_eff (eb), .mant (mb),
    .is_inf (b_inf), .is_nan (b_nan), .is_snan (b_snan)
  );

  assign sb_eff   = sb ^ sub;
  assign eff_sub  = sa ^ sb_eff;

  fpadd_align #(.EW(EXP_W), .MW(MANT_W), .XW(XTRA_W)) u_align (
    .exp_a (ea), .mant_a (ma), .exp_b (eb), .mant_b (mb),
    .swap (swap), .exp_big (exp_big),
    .big_ext (big_ext), .small_ext (small_ext)
  );

  assign sign_big = swap ? sb_eff : sa;
  assign sum      = eff_sub ? ({1'b0, big_ext} - {1'b0, small_ext})
                            : ({1'b0, big_ext} + {1'b0, small_ext});

  fpadd_norm_round #(.EW(EXP_W), .MW(MANT_W), .XW(XTRA_W)) u_nr (
    .exp_big (exp_big), .sum (sum), .sign (sign_big), .rmode (rmode),
    .res_word (nr_word), .ovf (nr_ovf), .unf (nr_unf), .inx (nr_inx)
  );

  assign zero_sign = eff_sub ? (rnd_mode_e'(rmode) == RND_DOWN) : sa;

  logic [WORD_W-1:0] nxt_res;
  logic              nxt_ovf, nxt_unf, nxt_inv, nxt_inx;

  always_comb begin
    nxt_res = nr_word;
    nxt_ovf = nr_ovf;
    nxt_unf = nr_unf;
    nxt_inv = 1'b0;
    nxt_inx = nr_inx;
    if (a_nan | b_nan) begin
      nxt_res = QNAN_WORD;
      {nxt_ovf, nxt_unf, nxt_inx} = '0;
      nxt_inv = a_snan | b_snan;
    end else if (a_inf & b_inf & eff_sub) begin
      nxt_res = QNAN_WORD;
      {nxt_ovf, nxt_unf, nxt_inx} = '0;
      nxt_inv = 1'b1;
    end else if (a_inf | b_inf) begin
      nxt_res = {a_inf ? sa : sb_eff, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      {nxt_ovf, nxt_unf, nxt_inx} = '0;
    end else if (sum == '0) begin
      nxt_res = {zero_sign, {(WORD_W-1){1'b0}}};
      {nxt_ovf, nxt_unf, nxt_inx} = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result   <= '0;
      flag_ovf <= 1'b0;
      flag_unf <= 1'b0;
      flag_inv <= 1'b0;
      flag_inx <= 1'b0;
    end else begin
      result   <= nxt_res;
      flag_ovf <= nxt_ovf;
      flag_unf <= nxt_unf;
      flag_inv <= nxt_inv;
      flag_inx <= nxt_inx;
    end
  end
endmodule

// File: rtl/fpadd_sp_chk.sv
module fpadd_sp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        sub,
  input logic [1:0]  rmode,
  input logic [31:0] result,
  input logic        flag_ovf,
  input logic        flag_unf,
  input logic        flag_inv,
  input logic        flag_inx
);
  logic a_nan, b_nan, a_inf, b_inf, opp, same_mag, a_fin;

  assign a_nan    = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 0);
  assign b_nan    = (op_b[30:23] == 8'hFF) && (op_b[22:0] != 0);
  assign a_inf    = (op_a[30:0] == 31'h7F800000);
  assign b_inf    = (op_b[30:0] == 31'h7F800000);
  assign opp      = op_a[31] ^ op_b[31] ^ sub;
  assign same_mag = (op_a[30:0] == op_b[30:0]);
  assign a_fin    = (op_a[30:23] != 8'hFF);

  p_nan_prop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_nan || b_nan) |=> (result == 32'h7FC00000));

  p_inv_is_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv |-> (result == 32'h7FC00000));

  p_inf_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_inf && b_inf && opp) |=> (result == 32'h7FC00000 && flag_inv));

  p_ovf_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> ((result[30:0] == 31'h7F800000 || result[30:0] == 31'h7F7FFFFF) && flag_inx));

  p_unf_tiny_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unf |-> (result[30:23] == 8'h00 && result[22:0] != 0 && !flag_ovf));

  p_zero_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fin && same_mag && opp && rmode != 2'b11) |=> (result == 32'h00000000));

  p_zero_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fin && same_mag && opp && rmode == 2'b11) |=> (result == 32'h80000000));
endmodule

bind fpadd_sp fpadd_sp_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .op_a     (op_a),
  .op_b     (op_b),
  .sub      (sub),
  .rmode    (rmode),
  .result   (result),
  .flag_ovf (flag_ovf),
  .flag_unf (flag_unf),
  .flag_inv (flag_inv),
  .flag_inx (flag_inx)
);

// File: tb/fpadd_sp_tb.sv
module fpadd_sp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 36;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic        sub;
  logic [1:0]  rmode;
  logic [31:0] result;
  logic        flag_ovf, flag_unf, flag_inv, flag_inx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpadd_sp u_dut (
    .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b),
    .sub (sub), .rmode (rmode), .result (result),
    .flag_ovf (flag_ovf), .flag_unf (flag_unf),
    .flag_inv (flag_inv), .flag_inx (flag_inx)
  );

  // {req, a, b, sub, rmode, expected result, expected {ovf,unf,inv,inx}}
  localparam logic [110:0] VEC [NVEC] = '{
    {8'd1,  32'h3F800000, 32'h40000000, 1'b0, 2'd0, 32'h40400000, 4'b0000}, // R1
    {8'd2,  32'h40400000, 32'h3F800000, 1'b1, 2'd0, 32'h40000000, 4'b0000}, // R2
    {8'd2,  32'h3FC00000, 32'hBF000000, 1'b0, 2'd0, 32'h3F800000, 4'b0000}, // R2
    {8'd2,  32'h40000000, 32'hBF800000, 1'b1, 2'd0, 32'h40400000, 4'b0000}, // R2
    {8'd3,  32'h3F800000, 32'h33800000, 1'b0, 2'd0, 32'h3F800000, 4'b0001}, // R3 tie, even
    {8'd3,  32'h3F800001, 32'h33800000, 1'b0, 2'd0, 32'h3F800002, 4'b0001}, // R3 tie, odd
    {8'd3,  32'h3F800000, 32'h33800000, 1'b0, 2'd2, 32'h3F800001, 4'b0001}, // R3 up
    {8'd3,  32'hBF800000, 32'hB3800000, 1'b0, 2'd3, 32'hBF800001, 4'b0001}, // R3 down
    {8'd3,  32'hBF800000, 32'hB3800000, 1'b0, 2'd1, 32'hBF800000, 4'b0001}, // R3 zero
    {8'd3,  32'h3F800000, 32'h00000001, 1'b0, 2'd2, 32'h3F800001, 4'b0001}, // R3 far sticky
    {8'd3,  32'h3F800000, 32'h00000001, 1'b0, 2'd0, 32'h3F800000, 4'b0001}, // R3
    {8'd3,  32'h3F800000, 32'h33000000, 1'b1, 2'd0, 32'h3F800000, 4'b0001}, // R3
    {8'd4,  32'h3FFFFFFF, 32'h33800000, 1'b0, 2'd0, 32'h40000000, 4'b0001}, // R4
    {8'd10, 32'h3F800000, 32'h33800000, 1'b1, 2'd0, 32'h3F7FFFFF, 4'b0000}, // R10 exact
    {8'd10, 32'h4B800000, 32'h3F800000, 1'b0, 2'd0, 32'h4B800000, 4'b0001}, // R10
    {8'd6,  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd0, 32'h7F800000, 4'b1001}, // R6
    {8'd6,  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd1, 32'h7F7FFFFF, 4'b1001}, // R6
    {8'd6,  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd3, 32'h7F7FFFFF, 4'b1001}, // R6
    {8'd6,  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd2, 32'h7F800000, 4'b1001}, // R6
    {8'd6,  32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 2'd2, 32'hFF7FFFFF, 4'b1001}, // R6
    {8'd6,  32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 2'd3, 32'hFF800000, 4'b1001}, // R6
    {8'd5,  32'h00000001, 32'h00000001, 1'b0, 2'd0, 32'h00000002, 4'b0100}, // R5
    {8'd5,  32'h00800000, 32'h00000001, 1'b1, 2'd0, 32'h007FFFFF, 4'b0100}, // R5
    {8'd5,  32'h00400000, 32'h00400000, 1'b0, 2'd0, 32'h00800000, 4'b0000}, // R5
    {8'd7,  32'h7FC00000, 32'h3F800000, 1'b0, 2'd0, 32'h7FC00000, 4'b0000}, // R7
    {8'd7,  32'h7F800001, 32'h00000000, 1'b0, 2'd0, 32'h7FC00000, 4'b0010}, // R7 signaling
    {8'd7,  32'hFFC12345, 32'h7F800000, 1'b1, 2'd0, 32'h7FC00000, 4'b0000}, // R7
    {8'd8,  32'h7F800000, 32'h7F800000, 1'b1, 2'd0, 32'h7FC00000, 4'b0010}, // R8
    {8'd8,  32'h7F800000, 32'hFF800000, 1'b0, 2'd0, 32'h7FC00000, 4'b0010}, // R8
    {8'd8,  32'hFF800000, 32'h7F7FFFFF, 1'b0, 2'd0, 32'hFF800000, 4'b0000}, // R8
    {8'd8,  32'h7F800000, 32'hFF800000, 1'b1, 2'd0, 32'h7F800000, 4'b0000}, // R8
    {8'd9,  32'h3F800000, 32'h3F800000, 1'b1, 2'd0, 32'h00000000, 4'b0000}, // R9
    {8'd9,  32'h3F800000, 32'h3F800000, 1'b1, 2'd3, 32'h80000000, 4'b0000}, // R9
    {8'd9,  32'h80000000, 32'h80000000, 1'b0, 2'd0, 32'h80000000, 4'b0000}, // R9
    {8'd9,  32'h80000000, 32'h00000000, 1'b0, 2'd3, 32'h80000000, 4'b0000}, // R9
    {8'd9,  32'hBF800000, 32'h3F800000, 1'b0, 2'd2, 32'h00000000, 4'b0000}  // R9
  };

  task automatic check(input int req, input logic [31:0] got_r, input logic [3:0] got_f,
                       input logic [31:0] exp_r, input logic [3:0] exp_f);
    checks++;
    if (got_r !== exp_r || got_f !== exp_f) begin
      errors++;
      $display("FAIL R%0d: result %h flags %b, expected %h flags %b",
               req, got_r, got_f, exp_r, exp_f);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic [1:0] rm);
    op_a = a; op_b = b; sub = s; rmode = rm;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(32'h3F800000, 32'h3F800000, 1'b0, 2'd0);
    repeat (3) @(negedge clk);
    // R11: outputs cleared during reset
    check(11, result, {flag_ovf, flag_unf, flag_inv, flag_inx}, 32'h0, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 latency: output changes only at the next edge
    drive(32'h3F800000, 32'h40000000, 1'b0, 2'd0);
    @(negedge clk);
    check(1, result, {flag_ovf, flag_unf, flag_inv, flag_inx}, 32'h40400000, 4'b0000);
    drive(32'h40400000, 32'h40400000, 1'b0, 2'd0);
    @(posedge clk);
    #1;
    check(1, result, {flag_ovf, flag_unf, flag_inv, flag_inx}, 32'h40C00000, 4'b0000);
    @(negedge clk);
    drive(32'h3F800000, 32'h3F800000, 1'b0, 2'd0);
    #(CLK_PERIOD/4);
    check(1, result, {flag_ovf, flag_unf, flag_inv, flag_inx}, 32'h40C00000, 4'b0000);
    @(negedge clk);
    check(1, result, {flag_ovf, flag_unf, flag_inv, flag_inx}, 32'h40000000, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][102:71], VEC[i][70:39], VEC[i][38], VEC[i][37:36]);
      @(negedge clk);
      check(int'(VEC[i][110:103]), result, {flag_ovf, flag_unf, flag_inv, flag_inx},
            VEC[i][35:4], VEC[i][3:0]);
    end

    // R6 back-to-back with R4: overflow then a rounding carry on the next cycle
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd1);
    @(negedge clk);
    drive(32'h3FFFFFFF, 32'h33800000, 1'b0, 2'd2);
    @(negedge clk);
    check(4, result, {flag_ovf, flag_unf, flag_inv, flag_inx}, 32'h40000000, 4'b0001);

    // R11: asynchronous reset mid-run clears outputs
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(11, result, {flag_ovf, flag_unf, flag_inv, flag_inx}, 32'h0, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, result, {flag_ovf, flag_unf, flag_inv, flag_inx}, 32'h7F800000, 4'b1001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule